// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Option

This block moves 36-bit words from a producer clocked by `wclk` to a consumer clocked by `rclk`. The two clocks may be unrelated or may be the very same clock. Each transfer happens on the rising edge of its own port clock, and only when that port's enable is high. Write and read pointers are kept in binary in their home domain. They cross to the other domain in Gray code through a two-flop synchronizer. Every status flag is therefore built from state that has passed two register stages on the clock of the side that uses it.

The `mode_ft` input is sampled while `rst` is high and selects one of two behaviours. In standard mode the read-side flag means "empty", the write-side flag means "full", and each word, the first one included, is presented only by an explicit read. In fall-through mode a one-word output register holds the head word. The read-side flag then means "output valid", the write-side flag means "space available", and the first word reaches the output without any read. The almost-empty and almost-full thresholds come from one of three presets picked at reset. A fourth reset code makes the first two write-port words after reset load the two thresholds.

Top module: `dual_clock_fifo`

## Requirements
- R1: While and after reset, with no traffic: standard mode gives rflag=1, wflag=0, almost_empty=1, almost_full=0 and rd_data=0. Fall-through mode gives rflag=0 and wflag=1, with the same almost flags.
- R2: Words leave in the order they were accepted, with no loss or duplication. With a shared clock, a write and a read on the same edge both take effect. Each pointer's Gray code changes in at most one bit per edge of its clock.
- R3: In standard mode, rd_data changes only on a rising rclk edge where rd_en=1 and the FIFO is not empty. A word written into an empty FIFO is not presented until such a read.
- R4: In fall-through mode, the head word appears on rd_data with rflag=1 and no read request. A rising rclk edge with rd_en=1 and rflag=1 advances to the next word. When no word remains, that edge clears rflag.
- R5: In standard mode wflag=1 means full (DEPTH words stored) and rflag=1 means empty. In fall-through mode wflag=1 means space is available and rflag=1 means rd_data holds a valid word. The fall-through store holds DEPTH+1 words (memory plus output register).
- R6: A write while the FIFO is full is ignored: nothing is stored and no pointer moves.
- R7: A read while the memory is empty (standard mode) or while rflag=0 (fall-through mode) is ignored: rd_data holds and no word is skipped.
- R8: almost_empty=1 exactly when the number of words held on the read side is at or below the almost-empty threshold. In fall-through mode this count includes the output register.
- R9: almost_full=1 exactly when the number of free memory locations is at or below the almost-full threshold.
- R10: ofs_sel sampled during reset sets both thresholds: code 0 gives 8, code 1 gives 16, code 2 gives 64.
- R11: With ofs_sel=3 at reset, the first accepted write sets the almost-empty threshold and the second sets the almost-full threshold. Each threshold is taken from wr_data[ADDR_W:0], and neither word is stored. Both thresholds are 8 until they are loaded.
- R12: With a shared clock, after a write into an empty FIFO on edge k, the standard-mode rflag falls after edge k+2 and not before. In fall-through mode rflag rises after edge k+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst | input | 1 | Synchronous active-high reset, held across edges of both clocks |
| mode_ft | input | 1 | Sampled at reset: 1 = fall-through mode, 0 = standard mode |
| ofs_sel | input | 2 | Sampled at reset: threshold preset code (0/1/2) or 3 for loading |
| wr_en | input | 1 | Write enable |
| wr_data | input | 36 | Write data, also the threshold word while loading |
| wflag | output | 1 | Full (standard mode) or space available (fall-through mode) |
| almost_full | output | 1 | Free locations at or below the almost-full threshold |
| rd_en | input | 1 | Read enable |
| rd_data | output | 36 | Read data |
| rflag | output | 1 | Empty (standard mode) or output valid (fall-through mode) |
| almost_empty | output | 1 | Held words at or below the almost-empty threshold |

## Verification
The assertions assume that `rst` is held long enough to span several edges of both clocks, and that `mode_ft` and `ofs_sel` change only while reset is applied. They also assume that the thresholds are loaded before the read side relies on them, since the almost-empty threshold is read across the clock boundary without a synchronizer. The stimulus changes mode and preset only inside its reset task. It waits a settling period after loading thresholds and before comparing almost flags. It issues writes and reads only on opposite clock edges, except for the deliberate ignored-access cases.

// File: rtl/dcf_pkg.sv
package dcf_pkg;

    localparam int DCF_DATA_W = 36;

    // reset-time threshold selection codes
    typedef enum logic [1:0] {
        SEL_8    = 2'd0,
        SEL_16   = 2'd1,
        SEL_64   = 2'd2,
        SEL_LOAD = 2'd3
    } ofs_sel_e;

    // threshold loading progress on the write side
    typedef enum logic [1:0] {
        LOAD_AE,
        LOAD_AF,
        LOAD_DONE
    } ofs_phase_e;

    function automatic int unsigned preset_offset(input logic [1:0] code);
        case (code)
            SEL_16:  return 16;
            SEL_64:  return 64;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
    parameter int PW = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [PW-1:0] gray_in,
    output logic [PW-1:0] gray_out,
    output logic [PW-1:0] bin_out
);

    logic [PW-1:0] stage1_q, stage2_q;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= gray_in;
            stage2_q <= stage1_q;
        end
    end

    assign gray_out = stage2_q;
    assign bin_out  = gray_to_bin(stage2_q);

endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 8
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] store [WORDS];

    always_ff @(posedge wclk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    assign rdata = store[raddr];

endmodule

// File: rtl/dcf_wside.sv
module dcf_wside
    import dcf_pkg::*;
#(
    parameter int ADDR_W = 8,
    localparam int PW = ADDR_W + 1
) (
    input  logic              wclk,
    input  logic              rst,
    input  logic              mode_ft,
    input  logic [1:0]        ofs_sel,
    input  logic              wr_en,
    input  logic [PW-1:0]     ofs_word,
    input  logic [PW-1:0]     rgray_s,
    input  logic [PW-1:0]     rbin_s,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [PW-1:0]     wgray,
    output logic [PW-1:0]     ae_ofs,
    output logic              full,
    output logic              almost_full,
    output logic              ft
);

    localparam logic [PW-1:0] DEPTH_C = PW'(1 << ADDR_W);

    logic [PW-1:0] wbin_q, wgray_q, wbin_nx;
    logic [PW-1:0] ae_q, af_q;
    logic [PW-1:0] used, free_cnt;
    ofs_phase_e    phase_q;
    logic          ft_q, loading, accept;

    assign wbin_nx  = wbin_q + 1'b1;
    assign used     = wbin_q - rbin_s;
    assign free_cnt = DEPTH_C - used;
    assign full     = (wgray_q == {~rgray_s[PW-1:PW-2], rgray_s[PW-3:0]});
    assign loading  = (phase_q != LOAD_DONE);
    assign accept   = wr_en && !full && !loading;

    always_ff @(posedge wclk) begin
        if (rst) begin
            wbin_q  <= '0;
            wgray_q <= '0;
            ft_q    <= mode_ft;
            if (ofs_sel == SEL_LOAD) begin
                phase_q <= LOAD_AE;
                ae_q    <= PW'(8);
                af_q    <= PW'(8);
            end else begin
                phase_q <= LOAD_DONE;
                ae_q    <= PW'(preset_offset(ofs_sel));
                af_q    <= PW'(preset_offset(ofs_sel));
            end
        end else begin
            if (accept) begin
                wbin_q  <= wbin_nx;
                wgray_q <= wbin_nx ^ (wbin_nx >> 1);
            end
            if (wr_en && loading) begin
                case (phase_q)
                    LOAD_AE: begin
                        ae_q    <= ofs_word;
                        phase_q <= LOAD_AF;
                    end
                    LOAD_AF: begin
                        af_q    <= ofs_word;
                        phase_q <= LOAD_DONE;
                    end
                    default: phase_q <= LOAD_DONE;
                endcase
            end
        end
    end

    assign mem_we      = accept;
    assign mem_waddr   = wbin_q[ADDR_W-1:0];
    assign wgray       = wgray_q;
    assign ae_ofs      = ae_q;
    assign almost_full = (free_cnt <= af_q);
    assign ft          = ft_q;

endmodule

// File: rtl/dcf_rside.sv
module dcf_rside #(
    parameter int DATA_W = 36,
    parameter int ADDR_W = 8,
    localparam int PW = ADDR_W + 1
) (
    input  logic              rclk,
    input  logic              rst,
    input  logic              mode_ft,
    input  logic              rd_en,
    input  logic [PW-1:0]     wgray_s,
    input  logic [PW-1:0]     wbin_s,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [PW-1:0]     ae_ofs,
    output logic [ADDR_W-1:0] mem_raddr,
    output logic [PW-1:0]     rgray,
    output logic [DATA_W-1:0] rd_data,
    output logic              mem_empty,
    output logic              ovalid,
    output logic              almost_empty,
    output logic              ft
);

    logic [PW-1:0]     rbin_q, rgray_q, rbin_nx, held;
    logic [DATA_W-1:0] data_q;
    logic              ov_q, ft_q, pop;

    assign rbin_nx   = rbin_q + 1'b1;
    assign mem_empty = (rgray_q == wgray_s);

    always_comb begin
        if (ft_q) begin
            pop = !mem_empty && (!ov_q || rd_en);
        end else begin
            pop = rd_en && !mem_empty;
        end
    end

    always_ff @(posedge rclk) begin
        if (rst) begin
            rbin_q  <= '0;
            rgray_q <= '0;
            data_q  <= '0;
            ov_q    <= 1'b0;
            ft_q    <= mode_ft;
        end else begin
            if (pop) begin
                rbin_q  <= rbin_nx;
                rgray_q <= rbin_nx ^ (rbin_nx >> 1);
                data_q  <= mem_rdata;
            end
            if (ft_q) begin
                if (pop) begin
                    ov_q <= 1'b1;
                end else if (rd_en) begin
                    ov_q <= 1'b0;
                end
            end
        end
    end

    assign held         = (wbin_s - rbin_q) + {{(PW-1){1'b0}}, ov_q};
    assign almost_empty = (held <= ae_ofs);
    assign mem_raddr    = rbin_q[ADDR_W-1:0];
    assign rgray        = rgray_q;
    assign rd_data      = data_q;
    assign ovalid       = ov_q;
    assign ft           = ft_q;

endmodule

// File: rtl/dual_clock_fifo.sv
module dual_clock_fifo #(
    parameter int DATA_W = dcf_pkg::DCF_DATA_W,
    parameter int DEPTH  = 256
) (
    input  logic              wclk,
    input  logic              rclk,
    input  logic              rst,
    input  logic              mode_ft,
    input  logic [1:0]        ofs_sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wflag,
    output logic              almost_full,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic              rflag,
    output logic              almost_empty
);

    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PW     = ADDR_W + 1;

    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s, wbin_s, rbin_s, ae_ofs;
    logic [ADDR_W-1:0] waddr, raddr;
    logic              mem_we, w_full, ft_w, r_mem_empty, r_ovalid, ft_r;
    logic [DATA_W-1:0] mem_q;

    dcf_wside #(.ADDR_W(ADDR_W)) u_wr (
        .wclk        (wclk),
        .rst         (rst),
        .mode_ft     (mode_ft),
        .ofs_sel     (ofs_sel),
        .wr_en       (wr_en),
        .ofs_word    (wr_data[PW-1:0]),
        .rgray_s     (rgray_s),
        .rbin_s      (rbin_s),
        .mem_we      (mem_we),
        .mem_waddr   (waddr),
        .wgray       (wgray),
        .ae_ofs      (ae_ofs),
        .full        (w_full),
        .almost_full (almost_full),
        .ft          (ft_w)
    );

    dcf_sync2 #(.PW(PW)) u_r2w (
        .clk      (wclk),
        .rst      (rst),
        .gray_in  (rgray),
        .gray_out (rgray_s),
        .bin_out  (rbin_s)
    );

    dcf_sync2 #(.PW(PW)) u_w2r (
        .clk      (rclk),
        .rst      (rst),
        .gray_in  (wgray),
        .gray_out (wgray_s),
        .bin_out  (wbin_s)
    );

    dcf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_q)
    );

    dcf_rside #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .rclk         (rclk),
        .rst          (rst),
        .mode_ft      (mode_ft),
        .rd_en        (rd_en),
        .wgray_s      (wgray_s),
        .wbin_s       (wbin_s),
        .mem_rdata    (mem_q),
        .ae_ofs       (ae_ofs),
        .mem_raddr    (raddr),
        .rgray        (rgray),
        .rd_data      (rd_data),
        .mem_empty    (r_mem_empty),
        .ovalid       (r_ovalid),
        .almost_empty (almost_empty),
        .ft           (ft_r)
    );

    assign wflag = ft_w ? ~w_full : w_full;
    assign rflag = ft_r ? r_ovalid : r_mem_empty;

endmodule

// File: rtl/dcf_checker.sv
module dcf_checker #(
    parameter int PW     = 9,
    parameter int DATA_W = 36
) (
    input logic              wclk,
    input logic              rclk,
    input logic              rst,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] rd_data,
    input logic              almost_full,
    input logic              almost_empty,
    input logic              w_full,
    input logic              r_mem_empty,
    input logic              r_ovalid,
    input logic              ft_r,
    input logic [PW-1:0]     wgray,
    input logic [PW-1:0]     rgray
);

    // R2
    wgray_step_chk: assert property (@(posedge wclk) disable iff (rst)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R2
    rgray_step_chk: assert property (@(posedge rclk) disable iff (rst)
        $countones(rgray ^ $past(rgray)) <= 1);

    // R3
    std_hold_chk: assert property (@(posedge rclk) disable iff (rst)
        !ft_r && !rd_en |=> $stable(rd_data));

    // R4
    ft_hold_chk: assert property (@(posedge rclk) disable iff (rst)
        ft_r && r_ovalid && !rd_en |=> r_ovalid && $stable(rd_data));

    // R6
    no_overflow_chk: assert property (@(posedge wclk) disable iff (rst)
        w_full && wr_en |=> $stable(wgray));

    // R7
    no_underflow_chk: assert property (@(posedge rclk) disable iff (rst)
        r_mem_empty |=> $stable(rgray));

    // R8
    ae_when_drained_chk: assert property (@(posedge rclk) disable iff (rst)
        r_mem_empty && !r_ovalid |-> almost_empty);

    // R9
    af_when_full_chk: assert property (@(posedge wclk) disable iff (rst)
        w_full |-> almost_full);

endmodule

bind dual_clock_fifo dcf_checker #(.PW(PW), .DATA_W(DATA_W)) u_chk (
    .wclk         (wclk),
    .rclk         (rclk),
    .rst          (rst),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .rd_data      (rd_data),
    .almost_full  (almost_full),
    .almost_empty (almost_empty),
    .w_full       (w_full),
    .r_mem_empty  (r_mem_empty),
    .r_ovalid     (r_ovalid),
    .ft_r         (ft_r),
    .wgray        (wgray),
    .rgray        (rgray)
);

// File: tb/test_dual_clock_fifo.sv
`timescale 1ns/1ps
module test_dual_clock_fifo;

    localparam int DW    = 36;
    localparam int DEPTH = 256;

    logic clk_a = 1'b0, clk_b = 1'b0, async_sel = 1'b0;
    logic wclk, rclk;
    logic rst = 1'b1, mode_ft = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [1:0] ofs_sel = 2'd0;
    logic [DW-1:0] wr_data = '0;
    logic wflag, almost_full, rflag, almost_empty;
    logic [DW-1:0] rd_data;

    int checks = 0, fails = 0;
    bit ft_mode = 1'b0;
    logic [DW-1:0] q[$];

    always #10 clk_a = ~clk_a;
    always #18 clk_b = ~clk_b;
    assign wclk = clk_a;
    assign rclk = async_sel ? clk_b : clk_a;

    dual_clock_fifo #(.DATA_W(DW), .DEPTH(DEPTH)) i_dual_clock_fifo (
        .wclk(wclk), .rclk(rclk), .rst(rst), .mode_ft(mode_ft), .ofs_sel(ofs_sel),
        .wr_en(wr_en), .wr_data(wr_data), .wflag(wflag), .almost_full(almost_full),
        .rd_en(rd_en), .rd_data(rd_data), .rflag(rflag), .almost_empty(almost_empty)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input bit ft, input logic [1:0] sel, input bit asy);
        @(negedge clk_a);
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
        mode_ft = ft; ofs_sel = sel; async_sel = asy; ft_mode = ft;
        q.delete();
        repeat (12) @(negedge clk_a);
        rst = 1'b0;
        repeat (2) @(negedge clk_a);
    endtask

    task automatic settle();
        repeat (10) @(negedge clk_b);
        @(negedge clk_a);
    endtask

    task automatic wr_one(input logic [DW-1:0] d);
        do @(negedge wclk); while (ft_mode ? !wflag : wflag);
        wr_en = 1'b1; wr_data = d; q.push_back(d);
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic wr_raw(input logic [DW-1:0] d);
        @(negedge wclk);
        wr_en = 1'b1; wr_data = d;
        @(negedge wclk);
        wr_en = 1'b0;
    endtask

    task automatic rd_one(input string tag);
        logic [DW-1:0] exp;
        if (ft_mode) begin
            do @(negedge rclk); while (!rflag);
            exp = (q.size() > 0) ? q.pop_front() : 'x;
            check(tag, rd_data, exp);
            rd_en = 1'b1;
            @(negedge rclk);
            rd_en = 1'b0;
        end else begin
            do @(negedge rclk); while (rflag);
            rd_en = 1'b1;
            @(negedge rclk);
            rd_en = 1'b0;
            exp = (q.size() > 0) ? q.pop_front() : 'x;
            check(tag, rd_data, exp);
        end
    endtask

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        // ---------------- standard mode, shared clock, preset 8
        do_reset(1'b0, 2'd0, 1'b0);
        check("R1 rflag", rflag, 1); check("R1 wflag", wflag, 0);
        check("R1 ae", almost_empty, 1); check("R1 af", almost_full, 0);
        check("R1 rd_data", rd_data, 0);
        @(negedge wclk); wr_en = 1'b1; wr_data = 36'h1_2345_6789; q.push_back(wr_data);
        @(negedge wclk); wr_en = 1'b0;
        @(negedge wclk); check("R12 std empty after k+1", rflag, 1);
        @(negedge wclk); check("R12 std empty after k+2", rflag, 0);
        settle();
        check("R3 not presented before read", rd_data, 0);
        rd_one("R3 first word");
        settle();
        check("R5 std empty again", rflag, 1);
        @(negedge rclk); rd_en = 1'b1; @(negedge rclk); rd_en = 1'b0;
        check("R7 std read on empty holds", rd_data, 36'h1_2345_6789);
        wr_one(36'h0_0000_00E1); settle(); rd_one("R7 no skip");
        // same-edge write and read
        for (int i = 0; i < 3; i++) wr_one(36'hF_0000_0000 | 36'(i));
        settle();
        @(negedge clk_a); wr_en = 1'b1; wr_data = 36'hF_0000_0003; q.push_back(wr_data); rd_en = 1'b1;
        @(negedge clk_a); wr_en = 1'b0; rd_en = 1'b0;
        check("R2 same-edge read", rd_data, q.pop_front());
        settle();
        for (int i = 0; i < 3; i++) rd_one("R2 same-edge order");
        settle();
        check("R2 drained", rflag, 1);
        // fill
        for (int i = 0; i < DEPTH; i++) begin
            wr_one(36'hA_0000_0000 | 36'(i * 7));
            if (i + 1 == DEPTH - 9) check("R9 af free=9", almost_full, 0);
            if (i + 1 == DEPTH - 8) check("R9 af free=8", almost_full, 1);
        end
        check("R5 std full", wflag, 1);
        @(negedge wclk); wr_en = 1'b1; wr_data = 36'hB_BAD0_BAD0; @(negedge wclk); wr_en = 1'b0;
        check("R6 still full", wflag, 1);
        settle();
        check("R8 ae at full", almost_empty, 0);
        for (int i = 0; i < DEPTH; i++) begin
            rd_one("R2 drain order");
            if (DEPTH - 1 - i == 9) check("R8 ae held=9", almost_empty, 0);
            if (DEPTH - 1 - i == 8) check("R8 ae held=8", almost_empty, 1);
        end
        settle();
        check("R6 extra word not stored", rflag, 1);
        check("R5 full released", wflag, 0);

        // ---------------- preset 16 and 64
        do_reset(1'b0, 2'd1, 1'b0);
        for (int i = 0; i < 16; i++) wr_one(36'(i));
        settle(); check("R10 sel1 held=16", almost_empty, 1);
        wr_one(36'h55); settle(); check("R10 sel1 held=17", almost_empty, 0);
        do_reset(1'b0, 2'd2, 1'b0);
        for (int i = 0; i < 64; i++) wr_one(36'(i));
        settle(); check("R10 sel2 held=64", almost_empty, 1);
        wr_one(36'h77); settle(); check("R10 sel2 held=65", almost_empty, 0);

        // ---------------- loaded thresholds: ae=5, af=10
        do_reset(1'b0, 2'd3, 1'b0);
        wr_raw(36'd5); wr_raw(36'd10);
        settle();
        check("R11 load words not stored", rflag, 1);
        for (int i = 0; i < 5; i++) wr_one(36'h3_0000_0000 | 36'(i));
        settle(); check("R11 ae held=5", almost_empty, 1);
        wr_one(36'h3_0000_0005); settle(); check("R11 ae held=6", almost_empty, 0);
        n = 6;
        while (n < DEPTH - 11) begin wr_one(36'(n)); n++; end
        check("R11 af free=11", almost_full, 0);
        wr_one(36'(n));
        check("R11 af free=10", almost_full, 1);

        // ---------------- fall-through mode, shared clock
        do_reset(1'b1, 2'd0, 1'b0);
        check("R1 ft rflag", rflag, 0); check("R1 ft wflag", wflag, 1);
        check("R1 ft ae", almost_empty, 1); check("R1 ft af", almost_full, 0);
        @(negedge wclk); wr_en = 1'b1; wr_data = 36'hC_0DE0_0001; q.push_back(wr_data);
        @(negedge wclk); wr_en = 1'b0;
        @(negedge wclk);
        @(negedge wclk); check("R12 ft not ready after k+2", rflag, 0);
        @(negedge wclk); check("R12 ft ready after k+3", rflag, 1);
        settle();
        check("R4 head shown without read", rd_data, 36'hC_0DE0_0001);
        check("R4 valid held", rflag, 1);
        wr_one(36'hC_0DE0_0002); wr_one(36'hC_0DE0_0003); settle();
        for (int i = 0; i < 3; i++) rd_one("R4 ft order");
        check("R4 ready clears on last", rflag, 0);
        @(negedge rclk); rd_en = 1'b1; @(negedge rclk); rd_en = 1'b0;
        wr_one(36'hD_0000_00D1); settle();
        check("R7 ft read ignored flag", rflag, 1);
        check("R7 ft read ignored data", rd_data, 36'hD_0000_00D1);
        rd_one("R7 ft consume");
        n = 0;
        for (int k = 0; k < DEPTH + 4; k++) begin
            repeat (3) @(negedge wclk);
            if (!wflag) break;
            wr_en = 1'b1; wr_data = 36'h9_0000_0000 | 36'(k); q.push_back(wr_data); n++;
            @(negedge wclk); wr_en = 1'b0;
        end
        check("R5 ft capacity", n, DEPTH + 1);
        check("R9 ft af at full", almost_full, 1);
        for (int i = 0; i < DEPTH + 1; i++) rd_one("R2 ft drain");
        settle();
        check("R5 ft empty", rflag, 0); check("R5 ft space", wflag, 1);

        // ---------------- unrelated clocks
        do_reset(1'b0, 2'd0, 1'b1);
        fork
            for (int i = 0; i < 300; i++) wr_one(36'h6_0000_0000 | 36'(i * 3));
            for (int i = 0; i < 300; i++) rd_one("R2 async std");
        join
        settle(); check("R5 async std empty", rflag, 1);
        do_reset(1'b1, 2'd0, 1'b1);
        fork
            for (int i = 0; i < 300; i++) wr_one(36'h7_0000_0000 | 36'(i * 5));
            for (int i = 0; i < 300; i++) rd_one("R2 async ft");
        join
        settle(); check("R4 async ft drained", rflag, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule